// File: doc/BRIEF.md
# Queued Byte-Serial Peripheral Master

This block is a serial peripheral (SPI) master that works through a short, host-built list of byte transfers without any help from the host on each byte. The host uses a simple register bus. It places outgoing bytes in a transmit file and places one command word for each slot in a command file. It then chooses a first slot and a last slot and sets the run bit. The sequencer fetches each slot in turn. It shifts the byte out in mode 0, most significant bit first, and stores the returned byte in a receive file. When the last slot is done, the run bit clears itself and a sticky completion flag is set.

Every command word decides whether chip select stays asserted after its byte, which chip-select lines take part, and whether a longer pause follows the byte. A hold bit in the control register keeps chip select asserted after the final slot, so that the next run continues the same serial transaction. A lock bit protects the transmit and command files from host writes.

Register map with the default parameters (byte addresses, data width 8). Transmit file: 0x00–0x1F. Receive file: 0x20–0x3F. Command file: 0x40–0x4F. Control: 0x50. Status: 0x51. First-slot pointer: 0x52. Last-slot pointer: 0x53. Lock: 0x54. A read returns the data for the address presented one cycle earlier.

Top module: `qspi_queue_ctrl`

## Requirements
- R1: After a synchronous reset, every chip-select line is high, the serial clock is low, and the control, status, pointer and lock registers all read 0.
- R2: The slot's byte is shifted out in mode 0, most significant bit first. The serial clock is idle low. Each clock phase lasts HALF_DIV system cycles. The transmit byte for slot i is written to the even address 2*i of the transmit file. Writes to odd addresses there are dropped.
- R3: The byte received for slot i can be read at the odd address 0x20+2*i+1. The even address 0x20+2*i reads 0.
- R4: A run executes the slots from the first pointer up to and including the last pointer, in ascending order, and wraps from slot 15 to slot 0. A run therefore moves between 1 and 16 bytes.
- R5: Command bit 0 (keep) holds chip select asserted after the byte. When the bit is clear, all chip-select lines return high once the byte has finished.
- R6: Command bits 5:2 are the per-line chip-select disables. While a byte is being shifted, chip-select line k is low only when bit 2+k of that slot's command word is 0.
- R7: Command bit 1 (long gap) adds GAP_LONG system cycles after the slot. Between the last falling serial-clock edge of a byte and the first rising edge of the next byte there are HALF_DIV+3 cycles, or HALF_DIV+3+GAP_LONG cycles when the long-gap bit is set.
- R8: Writing control bit 0 as 1 starts a run. The hardware clears the bit in the same cycle in which it sets status bit 0. Writing status with bit 0 equal to 0 clears the flag.
- R9: While a run is active, writes to the control register and to both pointers are ignored. Reads still return the live values.
- R10: While lock bit 0 is 1, writes to the transmit and command files are ignored.
- R11: Control bit 1 (hold) keeps chip select asserted after the final slot even when that slot's keep bit is clear. After a final slot with both bits clear, chip select is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the previous cycle's address |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low chip selects |

## Verification
The case that is hardest to reach is a host access that arrives in the middle of a running queue. Control and pointer writes issued at that point must leave the run untouched, and this can only be seen if the bench accesses the bus while serial bits are still moving. The bench starts a full 16-slot run and issues these writes partway through. It then counts the bytes that a model serial peripheral receives. The pause lengths between slots are measured in cycles from the serial-clock edges, and chip-select release events are counted against what the keep and hold bits predict.

// File: rtl/qspi_q_pkg.sv
`timescale 1ns/1ps
package qspi_q_pkg;
  localparam int CS_LINES = 4;
  localparam int BYTE_W   = 8;

  // per-slot command word: [0] keep, [1] long gap, [5:2] chip-select disables
  typedef struct packed {
    logic [CS_LINES-1:0] cs_off;
    logic                alt_gap;
    logic                keep;
  } qcmd_t;

  localparam int CMD_W = $bits(qcmd_t);

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_FETCH,
    SQ_START,
    SQ_SHIFT,
    SQ_GAP
  } seq_st_t;
endpackage

// File: rtl/qspi_sdp_ram.sv
`timescale 1ns/1ps
module qspi_sdp_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/qspi_byte_shifter.sv
`timescale 1ns/1ps
module qspi_byte_shifter #(
  parameter int HALF_DIV = 2,
  parameter int BITS     = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [BITS-1:0] tx_byte,
  input  logic            miso,
  output logic            sclk,
  output logic            mosi,
  output logic            busy,
  output logic            done,
  output logic [BITS-1:0] rx_byte
);
  localparam int CW  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BCW = $clog2(BITS);
  localparam logic [CW-1:0]  DIV_LAST = CW'(HALF_DIV - 1);
  localparam logic [BCW-1:0] BIT_LAST = BCW'(BITS - 1);

  logic [BITS-1:0] sh_tx, sh_rx;
  logic [BCW-1:0]  bitcnt;
  logic [CW-1:0]   divcnt;
  logic            sclk_q, busy_q, done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_tx  <= '0;
      sh_rx  <= '0;
      bitcnt <= '0;
      divcnt <= '0;
      sclk_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        sh_tx  <= tx_byte;
        bitcnt <= '0;
        divcnt <= '0;
        sclk_q <= 1'b0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (divcnt == DIV_LAST) begin
          divcnt <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            sh_rx  <= {sh_rx[BITS-2:0], miso};
          end else begin
            sclk_q <= 1'b0;
            sh_tx  <= {sh_tx[BITS-2:0], 1'b0};
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == BIT_LAST) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end else begin
          divcnt <= divcnt + 1'b1;
        end
      end
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = sh_tx[BITS-1];
  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_byte = sh_rx;

  // R2: the serial clock rests low outside a byte
  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !sclk_q);

  // R2: a clock edge only after a full phase count
  assert_sclk_phase_R2: assert property (@(posedge clk) disable iff (rst)
    (busy_q && (sclk_q != $past(sclk_q))) |-> ($past(divcnt) == DIV_LAST));
endmodule

// File: rtl/qspi_queue_ctrl.sv
`timescale 1ns/1ps
module qspi_queue_ctrl
  import qspi_q_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int HALF_DIV = 2,
  parameter int GAP_LONG = 4,
  parameter int AW       = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic [AW-1:0]       bus_addr,
  input  logic [BYTE_W-1:0]   bus_wdata,
  output logic [BYTE_W-1:0]   bus_rdata,
  output logic                spi_sclk,
  output logic                spi_mosi,
  input  logic                spi_miso,
  output logic [CS_LINES-1:0] spi_cs_n
);
  localparam int QW       = $clog2(DEPTH);
  localparam int RX_BASE  = 2 * DEPTH;
  localparam int CMD_BASE = 4 * DEPTH;
  localparam int REG_BASE = 5 * DEPTH;
  localparam logic [AW-1:0] A_CTRL  = AW'(REG_BASE);
  localparam logic [AW-1:0] A_STAT  = AW'(REG_BASE + 1);
  localparam logic [AW-1:0] A_FIRST = AW'(REG_BASE + 2);
  localparam logic [AW-1:0] A_LAST  = AW'(REG_BASE + 3);
  localparam logic [AW-1:0] A_LOCK  = AW'(REG_BASE + 4);
  localparam int GCW = $clog2(GAP_LONG + 1);
  localparam logic [GCW-1:0] GAP_END = GCW'(GAP_LONG - 1);

  // address decode
  logic in_tx, in_rx, in_cmd;
  assign in_tx  = int'(bus_addr) < RX_BASE;
  assign in_rx  = (int'(bus_addr) >= RX_BASE) && (int'(bus_addr) < CMD_BASE);
  assign in_cmd = (int'(bus_addr) >= CMD_BASE) && (int'(bus_addr) < REG_BASE);

  seq_st_t       state;
  logic [QW-1:0] ptr_q, first_q, last_q;
  logic          run_q, hold_q, fin_q, lock_q;
  logic          cs_act_q, cur_keep, cur_alt;
  logic [CS_LINES-1:0] cs_n_q;
  logic [GCW-1:0] gcnt;

  logic tx_we, cmd_we, rx_we;
  logic [BYTE_W-1:0] tx_rd, rx_rd, sh_rx;
  logic [CMD_W-1:0]  cmd_raw;
  qcmd_t             cmd_rd;
  logic sh_start, sh_busy, sh_done, sh_sclk, sh_mosi;
  logic at_last;

  assign tx_we   = bus_wr && in_tx && !bus_addr[0] && !lock_q;
  assign cmd_we  = bus_wr && in_cmd && !lock_q;
  assign cmd_rd  = qcmd_t'(cmd_raw);
  assign sh_start = (state == SQ_START);
  assign at_last  = (ptr_q == last_q);
  assign rx_we    = (state == SQ_SHIFT) && sh_done;

  qspi_sdp_ram #(.W(BYTE_W), .DEPTH(DEPTH)) u_tx_file (
    .clk(clk), .we(tx_we), .waddr(bus_addr[QW:1]), .wdata(bus_wdata),
    .raddr(ptr_q), .rdata(tx_rd));

  qspi_sdp_ram #(.W(CMD_W), .DEPTH(DEPTH)) u_cmd_file (
    .clk(clk), .we(cmd_we), .waddr(bus_addr[QW-1:0]),
    .wdata(bus_wdata[CMD_W-1:0]), .raddr(ptr_q), .rdata(cmd_raw));

  qspi_sdp_ram #(.W(BYTE_W), .DEPTH(DEPTH)) u_rx_file (
    .clk(clk), .we(rx_we), .waddr(ptr_q), .wdata(sh_rx),
    .raddr(bus_addr[QW:1]), .rdata(rx_rd));

  qspi_byte_shifter #(.HALF_DIV(HALF_DIV), .BITS(BYTE_W)) u_shifter (
    .clk(clk), .rst(rst), .start(sh_start), .tx_byte(tx_rd), .miso(spi_miso),
    .sclk(sh_sclk), .mosi(sh_mosi), .busy(sh_busy), .done(sh_done),
    .rx_byte(sh_rx));

  // sequencer and host registers
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      ptr_q    <= '0;
      first_q  <= '0;
      last_q   <= '0;
      run_q    <= 1'b0;
      hold_q   <= 1'b0;
      fin_q    <= 1'b0;
      lock_q   <= 1'b0;
      cs_act_q <= 1'b0;
      cs_n_q   <= '1;
      cur_keep <= 1'b0;
      cur_alt  <= 1'b0;
      gcnt     <= '0;
    end else begin
      if (bus_wr && !run_q) begin
        if (bus_addr == A_CTRL) begin
          hold_q <= bus_wdata[1];
          if (bus_wdata[0]) begin
            run_q <= 1'b1;
            ptr_q <= first_q;
            state <= SQ_FETCH;
          end
        end
        if (bus_addr == A_FIRST) first_q <= bus_wdata[QW-1:0];
        if (bus_addr == A_LAST)  last_q  <= bus_wdata[QW-1:0];
      end
      if (bus_wr && bus_addr == A_STAT && !bus_wdata[0]) fin_q <= 1'b0;
      if (bus_wr && bus_addr == A_LOCK) lock_q <= bus_wdata[0];

      case (state)
        SQ_FETCH: state <= SQ_START;
        SQ_START: begin
          cur_keep <= cmd_rd.keep;
          cur_alt  <= cmd_rd.alt_gap;
          cs_act_q <= 1'b1;
          cs_n_q   <= cmd_rd.cs_off;
          state    <= SQ_SHIFT;
        end
        SQ_SHIFT: begin
          if (sh_done) begin
            if (!cur_keep && !(at_last && hold_q)) begin
              cs_act_q <= 1'b0;
              cs_n_q   <= '1;
            end
            if (at_last) begin
              state <= SQ_IDLE;
              run_q <= 1'b0;
              fin_q <= 1'b1;
            end else begin
              ptr_q <= ptr_q + 1'b1;
              gcnt  <= '0;
              state <= cur_alt ? SQ_GAP : SQ_FETCH;
            end
          end
        end
        SQ_GAP: begin
          if (gcnt == GAP_END) state <= SQ_FETCH;
          else gcnt <= gcnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  // read path, one cycle latency
  logic              rx_sel_q;
  logic [BYTE_W-1:0] misc_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sel_q <= 1'b0;
      misc_q   <= '0;
    end else begin
      rx_sel_q <= in_rx && bus_addr[0];
      if (bus_addr == A_CTRL)       misc_q <= {6'b0, hold_q, run_q};
      else if (bus_addr == A_STAT)  misc_q <= {7'b0, fin_q};
      else if (bus_addr == A_FIRST) misc_q <= BYTE_W'(first_q);
      else if (bus_addr == A_LAST)  misc_q <= BYTE_W'(last_q);
      else if (bus_addr == A_LOCK)  misc_q <= {7'b0, lock_q};
      else                          misc_q <= '0;
    end
  end

  assign bus_rdata = rx_sel_q ? rx_rd : misc_q;
  assign spi_sclk  = sh_sclk;
  assign spi_mosi  = sh_mosi;
  assign spi_cs_n  = cs_n_q;

  // R5: a byte only moves while chip select is held active
  assert_shift_in_cs_R5: assert property (@(posedge clk) disable iff (rst)
    sh_busy |-> cs_act_q);

  // R8: end of run and completion flag go together
  assert_fin_on_stop_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(run_q) |-> fin_q);

  // R8: no serial activity without a run
  assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> !sh_busy);

  // R9: control writes during a run leave the hold bit alone
  assert_ctrl_locked_R9: assert property (@(posedge clk) disable iff (rst)
    (run_q && bus_wr && bus_addr == A_CTRL) |=> (hold_q == $past(hold_q)));

  // R9: pointer writes during a run leave the last pointer alone
  assert_ptr_locked_R9: assert property (@(posedge clk) disable iff (rst)
    (run_q && bus_wr && bus_addr == A_LAST) |=> (last_q == $past(last_q)));
endmodule

// File: tb/qspi_queue_ctrl_tb.sv
`timescale 1ns/1ps
module qspi_queue_ctrl_tb;
  localparam int CLK_P    = 10;
  localparam int HALF     = 2;
  localparam int GAPL     = 4;
  localparam int TXB = 0, RXB = 32, CMDB = 64;
  localparam int CTRL = 80, STAT = 81, PFIRST = 82, PLAST = 83, LCK = 84;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic spi_sclk, spi_mosi, spi_miso;
  logic [3:0] spi_cs_n;

  always #(CLK_P/2) clk = ~clk;

  qspi_queue_ctrl #(.DEPTH(16), .HALF_DIV(HALF), .GAP_LONG(GAPL), .AW(8)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

  int n_tests = 0;
  int n_fail  = 0;

  function automatic logic [7:0] sbyte(input int k);
    return 8'((k * 37 + 90) ^ (k >> 2));
  endfunction

  // model peripheral
  logic [7:0] sout, sin;
  int sbit = 0, scnt = 0, rises = 0, last_gap = 0;
  logic [7:0] cap [0:1023];
  logic [3:0] cs_seen = '1;
  realtime last_fall = 0;
  initial sout = sbyte(0);
  initial sin  = '0;
  assign spi_miso = sout[7];

  always @(posedge spi_sclk) begin
    if (sbit == 0) begin
      last_gap = int'(($realtime - last_fall) / CLK_P);
      cs_seen  = spi_cs_n;
    end
    sin = {sin[6:0], spi_mosi};
    sbit++;
  end

  always @(negedge spi_sclk) begin
    last_fall = $realtime;
    if (sbit == 8) begin
      cap[scnt] = sin;
      scnt++;
      sbit = 0;
      sout = sbyte(scnt);
    end else begin
      sout = {sout[6:0], 1'b0};
    end
  end

  always @(posedge spi_cs_n[0]) rises++;

  logic [7:0] txv [16];
  logic [5:0] cmdv [16];

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr  = 8'(a);
    bus_wdata = 8'(d);
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = 8'(a);
    bus_wr   = 1'b0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic put_slot(input int s, input logic [7:0] b, input logic [5:0] c);
    txv[s]  = b;
    cmdv[s] = c;
    wr(TXB + 2 * s, b);
    wr(CMDB + s, c);
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(CTRL, v);
      if (v[0] == 1'b0) return;
    end
    check("R8 run bit never cleared", 1, 0);
  endtask

  task automatic do_run(input int st, input int n, input bit hold);
    int base, r0, exp_r;
    logic [7:0] v;
    base = scnt;
    r0   = rises;
    wr(PFIRST, st);
    wr(PLAST, (st + n - 1) % 16);
    wr(CTRL, {6'b0, hold, 1'b1});
    wait_idle();
    check("R4 byte count", scnt - base, n);
    exp_r = 0;
    for (int j = 0; j < n; j++) begin
      int s;
      s = (st + j) % 16;
      check("R2 serial byte", cap[base + j], txv[s]);
      rd(RXB + 2 * s + 1, v);
      check("R3 received byte", v, sbyte(base + j));
      if (!cmdv[s][0] && !((j == n - 1) && hold)) exp_r++;
    end
    check("R5 chip-select releases", rises - r0, exp_r);
    rd(STAT, v);
    check("R8 finished flag set", v, 1);
    wr(STAT, 0);
    rd(STAT, v);
    check("R8 finished flag cleared", v, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2024));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    rises = 0;
    @(negedge clk);

    // R1 reset state
    check("R1 cs_n after reset", spi_cs_n, 4'hF);
    check("R1 sclk after reset", spi_sclk, 0);
    rd(CTRL, v);   check("R1 control", v, 0);
    rd(STAT, v);   check("R1 status", v, 0);
    rd(PFIRST, v); check("R1 first ptr", v, 0);
    rd(PLAST, v);  check("R1 last ptr", v, 0);
    rd(LCK, v);    check("R1 lock", v, 0);

    // random runs, including wrap past slot 15 (R4)
    for (int r = 0; r < 8; r++) begin
      int st, n;
      st = int'($urandom % 16);
      n  = 1 + int'($urandom % 16);
      for (int j = 0; j < n; j++)
        put_slot((st + j) % 16, 8'($urandom),
                 {4'b0, ($urandom % 4) == 0, 1'($urandom)});
      do_run(st, n, 1'b0);
    end

    // R4 directed wrap 14..1
    for (int j = 0; j < 4; j++) put_slot((14 + j) % 16, 8'hC0 + 8'(j), 6'b000000);
    do_run(14, 4, 1'b0);

    // R3 even receive word reads zero
    rd(RXB + 2 * 15, v);
    check("R3 even rx word", v, 0);

    // R2 odd transmit word dropped
    put_slot(9, 8'h5E, 6'b000000);
    wr(TXB + 2 * 9 + 1, 8'hFF);
    do_run(9, 1, 1'b0);
    check("R2 odd tx write dropped", cap[scnt - 1], 8'h5E);

    // R6 chip-select disables
    put_slot(3, 8'h81, {4'b0110, 1'b0, 1'b0});
    do_run(3, 1, 1'b0);
    check("R6 cs lines during byte", cs_seen, 4'b0110);
    check("R6 cs released after", spi_cs_n, 4'hF);

    // R7 long gap versus short gap
    put_slot(0, 8'h12, 6'b000011);
    put_slot(1, 8'h34, 6'b000000);
    do_run(0, 2, 1'b0);
    check("R7 long gap cycles", last_gap, HALF + 3 + GAPL);
    put_slot(0, 8'h12, 6'b000001);
    do_run(0, 2, 1'b0);
    check("R7 short gap cycles", last_gap, HALF + 3);

    // R9 writes during an active run
    begin
      int base;
      for (int s = 0; s < 16; s++) put_slot(s, 8'($urandom), {5'b0, s != 15});
      base = scnt;
      wr(PFIRST, 0);
      wr(PLAST, 15);
      wr(CTRL, 1);
      repeat (100) @(negedge clk);
      wr(CTRL, 8'h02);
      wr(PLAST, 2);
      wr(PFIRST, 7);
      rd(CTRL, v);   check("R9 control unchanged mid-run", v, 1);
      rd(PLAST, v);  check("R9 last ptr unchanged", v, 15);
      rd(PFIRST, v); check("R9 first ptr unchanged", v, 0);
      wait_idle();
      check("R9 full run completed", scnt - base, 16);
      wr(STAT, 0);
    end

    // R10 lock protects the files
    put_slot(5, 8'h3C, 6'b000000);
    wr(LCK, 1);
    rd(LCK, v); check("R10 lock reads set", v, 1);
    wr(TXB + 10, 8'hC3);
    wr(CMDB + 5, 6'b000001);
    wr(LCK, 0);
    do_run(5, 1, 1'b0);
    check("R10 locked tx write ignored", cap[scnt - 1], 8'h3C);
    check("R10 locked cmd write ignored", spi_cs_n, 4'hF);

    // R11 hold keeps chip select across runs
    put_slot(7, 8'hA7, 6'b000000);
    do_run(7, 1, 1'b1);
    check("R11 cs held after run", spi_cs_n[0], 0);
    rd(CTRL, v); check("R11 hold bit reads back", v, 2);
    do_run(7, 1, 1'b0);
    check("R11 cs released without hold", spi_cs_n, 4'hF);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule